// File: doc/BRIEF.md
# DMA Page Register Bank and Transfer Address Former

This block holds the upper address bits for each of four DMA channels and turns a channel's 16-bit current address into a full physical bus address for one burst. There are two register banks. The page bank holds eight bits per channel. The optional high-page bank also holds eight bits per channel, and only its low seven bits reach the bus address. The host reaches both banks with byte accesses at a three-bit port offset. That offset maps to a channel through a sparse, fixed decode, and four of its eight codes select nothing.

For a transfer step the caller supplies a channel number, the channel's mode byte, its current address, its programmed base count, and the position and length of the burst. One cycle after the start strobe the block presents four results: the physical start address of the burst, a flag that says whether the data order is reversed, the block length in bytes, and a one-cycle valid pulse. Bit 5 of the mode byte selects the direction. When it is clear the burst starts at the base address plus the position. When it is set, the whole burst is placed below the base address. The `WIDE` parameter selects byte or 16-bit transfer units, and that choice scales the block length.

Top module: `dma_page_addr`

## Requirements
- R1: The host port offset maps to a channel as follows: offset 1 selects channel 2, 2 selects channel 3, 3 selects channel 1 and 7 selects channel 0. A write stores `host_wdata` into the selected register. `host_rdata` always shows the addressed register without delay.
- R2: Offsets 0, 4, 5 and 6 are invalid. A write to one of them changes no register, and `host_rdata` reads 0 while one of them is addressed.
- R3: When `host_hi_sel` is 1, the access targets the high-page bank through the same decode. That bank stores and reads back all 8 bits. With `HIGH_EN`=0, high-page writes are ignored, high-page reads return 0, and the high page adds nothing to the address.
- R4: The burst base address is {high page bits 6:0, page bits 7:0, `cur_addr`} of channel `step_chan`, 31 bits wide. High-page bit 7 never appears in the address.
- R5: When mode bit 5 is 0, `phys_addr` = base + `burst_pos`, taken modulo 2^31, so a carry passes into the page bits, and `reverse` is 0.
- R6: When mode bit 5 is 1, `phys_addr` = base − `burst_pos` − `burst_len`, taken modulo 2^31, and `reverse` is 1. No other mode bit affects the outputs.
- R7: `blk_len` = (`base_count` + 1) << `WIDE`, computed without overflow (`WIDE`=1 is the default, the 16-bit unit).
- R8: `addr_valid` is 1 in exactly the cycle that follows a cycle with `step_start` high, and `phys_addr`, `reverse` and `blk_len` carry that step's results in that cycle.
- R9: Reset clears every page and high-page register to 0 and drives `addr_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| host_wr | input | 1 | Host byte write strobe |
| host_hi_sel | input | 1 | 0 selects the page bank, 1 selects the high-page bank |
| host_ofs | input | 3 | Host port offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed register |
| step_start | input | 1 | Start strobe for one address computation |
| step_chan | input | 2 | Channel number of the step |
| mode | input | 8 | Channel mode byte; bit 5 selects decrement |
| cur_addr | input | 16 | Channel current address |
| base_count | input | 16 | Programmed base count |
| burst_pos | input | 16 | Position of the burst within the block |
| burst_len | input | 16 | Length of the burst |
| addr_valid | output | 1 | One-cycle result valid |
| phys_addr | output | 31 | Physical start address of the burst |
| reverse | output | 1 | Data order is reversed |
| blk_len | output | 18 | Block length in bytes |

## Verification
The assertions are checked on every cycle. They cover four properties: registers that are not written keep their value, an invalid offset reads as zero, the valid pulse always follows a start strobe by exactly one cycle, and the block length never drops below one transfer unit. The bench scenarios are the only place where concrete values are shown. These are the channel mapping, the carry and borrow across the page boundary in both directions, the loss of high-page bit 7, and the disabled high-page variant.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;

    localparam int NCH    = 4;
    localparam int CH_W   = 2;
    localparam int OFS_W  = 3;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
    } ofs_dec_t;

    // sparse offset to channel map; unlisted offsets miss
    function automatic ofs_dec_t map_ofs(input logic [OFS_W-1:0] ofs);
        ofs_dec_t r;
        r.hit = 1'b1;
        r.ch  = '0;
        case (ofs)
            3'd1:    r.ch = 2'd2;
            3'd2:    r.ch = 2'd3;
            3'd3:    r.ch = 2'd1;
            3'd7:    r.ch = 2'd0;
            default: r.hit = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pg_port_decode.sv
module pg_port_decode
    import dma_pg_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    output logic             hit,
    output logic [CH_W-1:0]  ch
);
    ofs_dec_t dec;

    always_comb begin
        dec = map_ofs(ofs);
        hit = dec.hit;
        ch  = dec.ch;
    end
endmodule

// File: rtl/pg_bank.sv
module pg_bank #(
    parameter int N_CH = 4,
    parameter int DW   = 8,
    parameter bit EN   = 1'b1,
    localparam int SEL_W = $clog2(N_CH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_ch,
    input  logic [DW-1:0]             wdata,
    output logic [N_CH-1:0][DW-1:0]   regs_q
);
    generate
        if (EN) begin : g_on
            logic [N_CH-1:0][DW-1:0] regs_d;

            always_comb begin
                regs_d = regs_q;
                if (wr_en) begin
                    regs_d[wr_ch] = wdata;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q <= '0;
                end else begin
                    regs_q <= regs_d;
                end
            end

            // R1/R2: a register bank with no write strobe holds its contents
            p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(regs_q));
        end else begin : g_off
            logic unused_in;
            assign unused_in = ^{clk, rst_n, wr_en, wr_ch, wdata};
            assign regs_q    = '0;
        end
    endgenerate
endmodule

// File: rtl/pg_addr_gen.sv
module pg_addr_gen #(
    parameter int AW   = 16,
    parameter int PW   = 8,
    parameter int HW   = 7,
    parameter int CW   = 16,
    parameter int WIDE = 1,
    localparam int PHYS_W = HW + PW + AW,
    localparam int LEN_W  = CW + 1 + WIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dec_mode,
    input  logic [HW-1:0]     hpage,
    input  logic [PW-1:0]     page,
    input  logic [AW-1:0]     cur,
    input  logic [CW-1:0]     bcnt,
    input  logic [AW-1:0]     pos,
    input  logic [AW-1:0]     len,
    output logic              vld,
    output logic              rev,
    output logic [PHYS_W-1:0] addr,
    output logic [LEN_W-1:0]  blen
);
    typedef struct packed {
        logic              vld;
        logic              rev;
        logic [PHYS_W-1:0] addr;
        logic [LEN_W-1:0]  blen;
    } res_t;

    res_t res_d, res_q;
    logic [PHYS_W-1:0] base_w, pos_w, len_w;
    logic [LEN_W-1:0]  units;

    always_comb begin
        base_w = {hpage, page, cur};
        pos_w  = PHYS_W'(pos);
        len_w  = PHYS_W'(len);
        units  = LEN_W'(bcnt) + LEN_W'(1);

        res_d      = res_q;
        res_d.vld  = start;
        if (start) begin
            res_d.rev  = dec_mode;
            res_d.blen = units << WIDE;
            if (dec_mode) begin
                res_d.addr = base_w - pos_w - len_w;
            end else begin
                res_d.addr = base_w + pos_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign vld  = res_q.vld;
    assign rev  = res_q.rev;
    assign addr = res_q.addr;
    assign blen = res_q.blen;

    // R8: the result pulse appears only right after a start strobe
    p_vld_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(start));
    // R8: a start strobe always produces a result pulse
    p_start_gives_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> vld);
    // R7: the length is at least one transfer unit
    p_len_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (blen >= (LEN_W'(1) << WIDE)));
endmodule

// File: rtl/dma_page_addr.sv
module dma_page_addr
    import dma_pg_pkg::*;
#(
    parameter int WIDE    = 1,
    parameter bit HIGH_EN = 1'b1,
    parameter int AW      = 16,
    parameter int CW      = 16,
    localparam int HW     = BYTE_W - 1,
    localparam int PHYS_W = HW + BYTE_W + AW,
    localparam int LEN_W  = CW + 1 + WIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_hi_sel,
    input  logic [OFS_W-1:0]  host_ofs,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              step_start,
    input  logic [CH_W-1:0]   step_chan,
    input  logic [7:0]        mode,
    input  logic [AW-1:0]     cur_addr,
    input  logic [CW-1:0]     base_count,
    input  logic [AW-1:0]     burst_pos,
    input  logic [AW-1:0]     burst_len,
    output logic              addr_valid,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              reverse,
    output logic [LEN_W-1:0]  blk_len
);
    localparam int DIR_BIT = 5;

    logic                         dec_hit;
    logic [CH_W-1:0]              dec_ch;
    logic                         pg_we, hp_we;
    logic [NCH-1:0][BYTE_W-1:0]   pg_q, hp_q;
    logic [BYTE_W-1:0]            rd_d;
    logic [BYTE_W-1:0]            sel_hp;
    logic                         unused_mode;

    pg_port_decode u_dec (
        .ofs (host_ofs),
        .hit (dec_hit),
        .ch  (dec_ch)
    );

    always_comb begin
        pg_we = host_wr && dec_hit && !host_hi_sel;
        hp_we = host_wr && dec_hit &&  host_hi_sel;
    end

    pg_bank #(.N_CH(NCH), .DW(BYTE_W), .EN(1'b1)) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pg_we),
        .wr_ch  (dec_ch),
        .wdata  (host_wdata),
        .regs_q (pg_q)
    );

    pg_bank #(.N_CH(NCH), .DW(BYTE_W), .EN(HIGH_EN)) u_hpage (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (hp_we),
        .wr_ch  (dec_ch),
        .wdata  (host_wdata),
        .regs_q (hp_q)
    );

    always_comb begin
        rd_d = '0;
        if (dec_hit) begin
            rd_d = host_hi_sel ? hp_q[dec_ch] : pg_q[dec_ch];
        end
        host_rdata = rd_d;
        sel_hp     = hp_q[step_chan];
    end

    assign unused_mode = ^{mode[7:DIR_BIT+1], mode[DIR_BIT-1:0], sel_hp[BYTE_W-1]};

    pg_addr_gen #(
        .AW(AW), .PW(BYTE_W), .HW(HW), .CW(CW), .WIDE(WIDE)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (step_start),
        .dec_mode (mode[DIR_BIT]),
        .hpage    (sel_hp[HW-1:0]),
        .page     (pg_q[step_chan]),
        .cur      (cur_addr),
        .bcnt     (base_count),
        .pos      (burst_pos),
        .len      (burst_len),
        .vld      (addr_valid),
        .rev      (reverse),
        .addr     (phys_addr),
        .blen     (blk_len)
    );

    // R2: an offset that maps to no channel reads as zero
    p_invalid_rd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> (host_rdata == '0));
    // R3: with the high bank disabled the top address bits stay clear on a forward step
    p_hidis_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!HIGH_EN && addr_valid && !reverse && $past(cur_addr) == '0 && $past(burst_pos) == '0)
        |-> (phys_addr[PHYS_W-1:PHYS_W-HW] == '0));
endmodule

// File: tb/sim_dma_page_addr.sv
module sim_dma_page_addr;
    localparam int LEN_W = 18;

    typedef struct packed {
        logic [1:0]  ch;
        logic [7:0]  md;
        logic [15:0] cur;
        logic [15:0] pos;
        logic [15:0] len;
        logic [15:0] bcnt;
        logic [30:0] exp_addr;
        logic [17:0] exp_len;
    } vec_t;

    // pages: ch0 12/81, ch1 34/02, ch2 56/7F, ch3 78/00
    localparam vec_t VEC [6] = '{
        '{2'd0, 8'h48, 16'h1000, 16'h0010, 16'h0004, 16'h0003, 31'h0112_1010, 18'h00008},
        '{2'd1, 8'h48, 16'hFFFF, 16'h0002, 16'h0001, 16'hFFFF, 31'h0235_0001, 18'h20000},
        '{2'd2, 8'h68, 16'h0100, 16'h0010, 16'h0020, 16'h0000, 31'h7F56_00D0, 18'h00002},
        '{2'd3, 8'h20, 16'h0000, 16'h0000, 16'h0001, 16'h0005, 31'h0077_FFFF, 18'h0000C},
        '{2'd0, 8'hFF, 16'h2000, 16'h0000, 16'h0000, 16'h7FFF, 31'h0112_2000, 18'h10000},
        '{2'd2, 8'hDF, 16'hABCD, 16'h0100, 16'h0050, 16'h00FF, 31'h7F56_ACCD, 18'h00200}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_hi_sel = 1'b0;
    logic [2:0]  host_ofs = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  rdata0, rdata1;
    logic        step_start = 1'b0;
    logic [1:0]  step_chan = '0;
    logic [7:0]  mode = '0;
    logic [15:0] cur_addr = '0, base_count = '0, burst_pos = '0, burst_len = '0;
    logic        vld0, vld1, rev0, rev1;
    logic [30:0] addr0, addr1;
    logic [LEN_W-1:0] len0, len1;
    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dma_page_addr u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_hi_sel(host_hi_sel),
        .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(rdata0),
        .step_start(step_start), .step_chan(step_chan), .mode(mode),
        .cur_addr(cur_addr), .base_count(base_count), .burst_pos(burst_pos),
        .burst_len(burst_len), .addr_valid(vld0), .phys_addr(addr0),
        .reverse(rev0), .blk_len(len0)
    );

    dma_page_addr #(.HIGH_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_hi_sel(host_hi_sel),
        .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(rdata1),
        .step_start(step_start), .step_chan(step_chan), .mode(mode),
        .cur_addr(cur_addr), .base_count(base_count), .burst_pos(burst_pos),
        .burst_len(burst_len), .addr_valid(vld1), .phys_addr(addr1),
        .reverse(rev1), .blk_len(len1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic hi, input logic [2:0] ofs, input logic [7:0] d);
        @(negedge clk);
        host_hi_sel = hi; host_ofs = ofs; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic hi, input logic [2:0] ofs);
        @(negedge clk);
        host_hi_sel = hi; host_ofs = ofs;
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 valid low", {31'd0, vld0}, 32'd0);
        rst_n = 1'b1;
        for (int o = 0; o < 8; o++) begin
            hread(1'b0, 3'(o)); chk("R9 page zero", {24'd0, rdata0}, 32'd0);
            hread(1'b1, 3'(o)); chk("R9 hpage zero", {24'd0, rdata0}, 32'd0);
        end

        // R1, R3: program both banks through the decode
        hwrite(1'b0, 3'd7, 8'h12); hwrite(1'b0, 3'd3, 8'h34);
        hwrite(1'b0, 3'd1, 8'h56); hwrite(1'b0, 3'd2, 8'h78);
        hwrite(1'b1, 3'd7, 8'h81); hwrite(1'b1, 3'd3, 8'h02);
        hwrite(1'b1, 3'd1, 8'h7F); hwrite(1'b1, 3'd2, 8'h00);
        // R2: writes to invalid offsets in both banks
        for (int o = 4; o < 7; o++) begin
            hwrite(1'b0, 3'(o), 8'hAA); hwrite(1'b1, 3'(o), 8'hAA);
        end
        hwrite(1'b0, 3'd0, 8'hAA); hwrite(1'b1, 3'd0, 8'hAA);

        hread(1'b0, 3'd7); chk("R1 ofs7 page", {24'd0, rdata0}, 32'h12);
        hread(1'b0, 3'd3); chk("R1 ofs3 page", {24'd0, rdata0}, 32'h34);
        hread(1'b0, 3'd1); chk("R1 ofs1 page", {24'd0, rdata0}, 32'h56);
        hread(1'b0, 3'd2); chk("R1 ofs2 page", {24'd0, rdata0}, 32'h78);
        hread(1'b1, 3'd7); chk("R3 hpage 8 bits", {24'd0, rdata0}, 32'h81);
        hread(1'b1, 3'd1); chk("R3 hpage ofs1", {24'd0, rdata0}, 32'h7F);
        hread(1'b1, 3'd7); chk("R3 disabled hpage reads 0", {24'd0, rdata1}, 32'h0);
        hread(1'b0, 3'd2); chk("R3 disabled variant page", {24'd0, rdata1}, 32'h78);
        for (int o = 0; o < 7; o++) begin
            if (o == 0 || o > 3) begin
                hread(1'b0, 3'(o)); chk("R2 invalid read 0", {24'd0, rdata0}, 32'd0);
                hread(1'b1, 3'(o)); chk("R2 invalid hread 0", {24'd0, rdata0}, 32'd0);
            end
        end

        // R4-R8: vector table
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            step_chan = VEC[i].ch; mode = VEC[i].md; cur_addr = VEC[i].cur;
            burst_pos = VEC[i].pos; burst_len = VEC[i].len; base_count = VEC[i].bcnt;
            step_start = 1'b1;
            chk("R8 no valid before start", {31'd0, vld0}, 32'd0);
            @(negedge clk);
            step_start = 1'b0;
            chk("R8 valid after start", {31'd0, vld0}, 32'd1);
            chk(VEC[i].md[5] ? "R6 reverse addr" : "R5 forward addr R4", {1'b0, addr0}, {1'b0, VEC[i].exp_addr});
            chk(VEC[i].md[5] ? "R6 reverse flag" : "R5 forward flag", {31'd0, rev0}, {31'd0, VEC[i].md[5]});
            chk("R7 block length", {14'd0, len0}, {14'd0, VEC[i].exp_len});
            chk("R3 disabled hpage addr", {1'b0, addr1}, {1'b0, VEC[i].exp_addr & 31'h00FF_FFFF});
            @(negedge clk);
            chk("R8 valid single cycle", {31'd0, vld0}, 32'd0);
        end

        // R8: back-to-back strobes each give a result
        @(negedge clk);
        step_chan = 2'd1; mode = 8'h00; cur_addr = 16'h0005; burst_pos = 16'h0001;
        base_count = 16'h0001; step_start = 1'b1;
        @(negedge clk);
        chk("R8 b2b first", {1'b0, addr0}, 32'h0234_0006);
        cur_addr = 16'h0009;
        @(negedge clk);
        step_start = 1'b0;
        chk("R8 b2b second valid", {31'd0, vld0}, 32'd1);
        chk("R8 b2b second", {1'b0, addr0}, 32'h0234_000A);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule